// File: doc/BRIEF.md
# I2C Slave Receive Engine with Address Matching

This block is the receive side of an I2C target device. It synchronizes the raw SCL and SDA lines to the system clock and detects start and stop conditions. It shifts bus bits into a byte register, most significant bit first, on each rising SCL edge. The first byte after a start is the address byte. A 7-bit address is compared directly. A byte whose top five bits are 11110 is taken as the 10-bit address preamble: it switches the engine into 10-bit addressing, and the next byte completes the comparison. The engine acknowledges only address bytes that match and data bytes it can store. It does so by pulling SDA low for the ninth clock of the byte. SDA is open-drain, so the block never drives it high.

Data bytes are double buffered. A completed byte moves from the shift register into a holding register and sets a full flag, which serves as the interrupt. The shift register is then free for the next byte. Software empties the holding register with a one-cycle read strobe. If a byte completes while the holding register is still full, the byte is dropped, an overflow flag is raised and the byte is not acknowledged.

The controlling state machine has five states. IDLE is left only on a start. ADDR_HI evaluates the first byte: it goes to ADDR_LO on a matching preamble, to RECV on a matching 7-bit write address, and to SKIP on a 7-bit read address or on any mismatch. ADDR_LO goes to RECV on a matching low byte and to SKIP otherwise. RECV stays put and takes data. SKIP ignores the bus. From any state a start goes to ADDR_HI and a stop goes to IDLE.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, sda_pull, rx_full, overflow, start_seen, stop_seen, ten_bit, addr_match, rw_bit and rx_data are all 0.
- R2: SDA falling while SCL is high sets start_seen and clears stop_seen. SDA rising while SCL is high sets stop_seen and clears start_seen. The two flags are never 1 together.
- R3: Bits are taken on rising SCL edges, most significant first. A data byte appears in rx_data exactly as the master sent it.
- R4: In the first byte after a start, if bits 7:3 are not 11110 and bits 7:1 equal own_addr[6:0], the byte is acknowledged, addr_match becomes 1 and rw_bit takes bit 0 of the byte.
- R5: A first byte that matches neither form is not acknowledged. No later byte before the next start is acknowledged or stored.
- R6: A first byte with bits 7:3 = 11110 sets ten_bit. It is acknowledged when bits 2:1 equal own_addr[9:8] and bit 0 is 0. A following byte equal to own_addr[7:0] is then acknowledged and sets addr_match.
- R7: In 10-bit addressing, a second byte not equal to own_addr[7:0] is not acknowledged and leaves addr_match at 0. Later data is neither acknowledged nor stored.
- R8: After a matching write address, each data byte accepted while rx_full is 0 is copied to rx_data, sets rx_full and is acknowledged.
- R9: A one-cycle rd_strobe clears rx_full (and overflow), after which the next data byte is accepted.
- R10: A data byte that completes while rx_full is 1 sets overflow, is not acknowledged, and leaves rx_data unchanged.
- R11: A matching 7-bit address with bit 0 = 1 (read) is acknowledged, but following bytes are neither acknowledged nor stored.
- R12: sda_pull rises only on the SCL falling edge that ends the eighth bit, and only for an acknowledged byte. It falls on the next SCL falling edge and is 0 after a stop.
- R13: A start or a stop clears addr_match and ten_bit. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_addr | input | 10 | Programmed slave address (bits 6:0 used in 7-bit mode) |
| rd_strobe | input | 1 | One-cycle pulse that empties the holding register |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain), 0 = release |
| rx_data | output | 8 | Holding register with the last accepted byte |
| rx_full | output | 1 | Holding register full (interrupt flag) |
| overflow | output | 1 | A byte was dropped because the holding register was full |
| start_seen | output | 1 | Last bus condition was a start |
| stop_seen | output | 1 | Last bus condition was a stop |
| ten_bit | output | 1 | 10-bit addressing preamble seen in this transfer |
| addr_match | output | 1 | The slave is addressed in this transfer |
| rw_bit | output | 1 | Direction bit of the matched address (1 = read) |

## Verification
A wrong state shows up at the ports within one byte. It appears as an acknowledge bit of the wrong polarity in the ninth clock of the byte that follows, or as rx_data, rx_full or overflow differing from the model right after that byte's acknowledge slot. A miscounted bit position shifts every later byte and breaks the acknowledge timing on the next byte boundary. Address faults show in addr_match, ten_bit and rw_bit just after the address byte. They also show in whether any later byte of the transfer is stored.

// File: rtl/i2c_rx_pkg.sv
`timescale 1ns/1ps
package i2c_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RECV,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
`timescale 1ns/1ps
module i2c_rx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], raw_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
        assign prev_o[g] = chain[STAGES];
    end
endmodule

// File: rtl/i2c_rx_events.sv
`timescale 1ns/1ps
module i2c_rx_events (
    input  logic scl_i,
    input  logic sda_i,
    input  logic scl_q_i,
    input  logic sda_q_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_steady_hi;
    assign scl_steady_hi = scl_i & scl_q_i;
    assign scl_rise_o = scl_i & ~scl_q_i;
    assign scl_fall_o = ~scl_i & scl_q_i;
    assign start_o    = scl_steady_hi & sda_q_i & ~sda_i;
    assign stop_o     = scl_steady_hi & ~sda_q_i & sda_i;
endmodule

// File: rtl/i2c_rx_shifter.sv
`timescale 1ns/1ps
module i2c_rx_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] byte_nx_o,
    output logic             done_o,
    output logic             ack_slot_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-2:0] sr;
    logic [CNT_W-1:0] cnt;

    assign byte_nx_o  = {sr, bit_i};
    assign done_o     = shift_i && (cnt == CNT_W'(WIDTH - 1));
    assign ack_slot_o = (cnt == CNT_W'(WIDTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clear_i) begin
            cnt <= '0;
        end else if (shift_i) begin
            if (cnt == CNT_W'(WIDTH)) begin
                cnt <= '0;
            end else begin
                sr  <= byte_nx_o[WIDTH-2:0];
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_slave_rx.sv
`timescale 1ns/1ps
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rd_strobe,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overflow,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              ten_bit,
    output logic              addr_match,
    output logic              rw_bit
);
    logic [1:0] line_s, line_q;
    logic scl_s, sda_s, scl_q, sda_q;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] byte_nx;
    logic byte_done, ack_slot;
    logic ack_pend, ack_now;
    logic is_pre, pre_hit, hit7, room, store, drop;
    rx_state_t st, st_nx;

    i2c_rx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_in, sda_in}),
        .sync_o(line_s), .prev_o(line_q)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];
    assign scl_q = line_q[1];
    assign sda_q = line_q[0];

    i2c_rx_events i_events (
        .scl_i(scl_s), .sda_i(sda_s), .scl_q_i(scl_q), .sda_q_i(sda_q),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    i2c_rx_shifter #(.WIDTH(BYTE_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .clear_i(start_ev), .shift_i(scl_rise),
        .bit_i(sda_s), .byte_nx_o(byte_nx), .done_o(byte_done),
        .ack_slot_o(ack_slot)
    );

    // Address decode on the byte being completed
    assign is_pre  = (byte_nx[7:3] == TEN_BIT_PREFIX);
    assign pre_hit = is_pre && (byte_nx[2:1] == own_addr[9:8]) && !byte_nx[0];
    assign hit7    = !is_pre && (byte_nx[7:1] == own_addr[6:0]);
    assign room    = !rx_full || rd_strobe;
    assign store   = byte_done && (st == ST_RECV) && room;
    assign drop    = byte_done && (st == ST_RECV) && !room;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state and acknowledge decision
    always_comb begin
        st_nx   = st;
        ack_now = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ADDR_HI: begin
                if (byte_done) begin
                    if (pre_hit) begin
                        ack_now = 1'b1;
                        st_nx   = ST_ADDR_LO;
                    end else if (hit7) begin
                        ack_now = 1'b1;
                        st_nx   = byte_nx[0] ? ST_SKIP : ST_RECV;
                    end else begin
                        st_nx   = ST_SKIP;
                    end
                end
            end
            ST_ADDR_LO: begin
                if (byte_done) begin
                    if (byte_nx == own_addr[7:0]) begin
                        ack_now = 1'b1;
                        st_nx   = ST_RECV;
                    end else begin
                        st_nx   = ST_SKIP;
                    end
                end
            end
            ST_RECV: ack_now = store;
            ST_SKIP: ;
            default: st_nx = ST_IDLE;
        endcase
        if (stop_ev)  st_nx = ST_IDLE;
        if (start_ev) st_nx = ST_ADDR_HI;
    end

    // Outputs: bus conditions, address status, acknowledge drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            ten_bit    <= 1'b0;
            addr_match <= 1'b0;
            rw_bit     <= 1'b0;
            ack_pend   <= 1'b0;
            sda_pull   <= 1'b0;
        end else if (start_ev || stop_ev) begin
            start_seen <= start_ev;
            stop_seen  <= stop_ev;
            ten_bit    <= 1'b0;
            addr_match <= 1'b0;
            ack_pend   <= 1'b0;
            sda_pull   <= 1'b0;
        end else begin
            if (byte_done) begin
                ack_pend <= ack_now;
                if (st == ST_ADDR_HI && is_pre) ten_bit <= 1'b1;
                if (st == ST_ADDR_HI && hit7) begin
                    addr_match <= 1'b1;
                    rw_bit     <= byte_nx[0];
                end
                if (st == ST_ADDR_LO && ack_now) begin
                    addr_match <= 1'b1;
                    rw_bit     <= 1'b0;
                end
            end
            if (scl_fall) sda_pull <= ack_slot && ack_pend;
        end
    end

    // Holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_full  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (store) begin
                rx_data <= byte_nx;
                rx_full <= 1'b1;
            end else if (rd_strobe) begin
                rx_full <= 1'b0;
            end
            if (drop)           overflow <= 1'b1;
            else if (rd_strobe) overflow <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
`timescale 1ns/1ps
module i2c_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_ev,
    input logic       sda_pull,
    input logic       rx_full,
    input logic       overflow,
    input logic [7:0] rx_data,
    input logic       addr_match,
    input logic       ten_bit,
    input logic       start_seen,
    input logic       stop_seen
);
    AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen)); // R2
    AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(!scl_s)); // R12
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull); // R12
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (rx_full && $stable(rx_data))); // R10
    AST_FULL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> addr_match); // R8
    AST_TEN_CLEARED_BY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ten_bit) |-> (start_seen || stop_seen)); // R13
endmodule

bind i2c_slave_rx i2c_slave_rx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_ev(stop_ev),
    .sda_pull(sda_pull), .rx_full(rx_full), .overflow(overflow),
    .rx_data(rx_data), .addr_match(addr_match), .ten_bit(ten_bit),
    .start_seen(start_seen), .stop_seen(stop_seen)
);

// File: tb/test_i2c_slave_rx.sv
`timescale 1ns/1ps
module test_i2c_slave_rx;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [9:0] own = 10'h000;
    logic rd = 1'b0;
    logic sda_bus;
    logic sda_pull, rx_full, overflow, start_seen, stop_seen, ten_bit, addr_match, rw_bit;
    logic [7:0] rx_data;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_slave_rx i_i2c_slave_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .own_addr(own), .rd_strobe(rd), .sda_pull(sda_pull), .rx_data(rx_data),
        .rx_full(rx_full), .overflow(overflow), .start_seen(start_seen),
        .stop_seen(stop_seen), .ten_bit(ten_bit), .addr_match(addr_match),
        .rw_bit(rw_bit)
    );

    int checks = 0, errors = 0;
    // bench model: 0 idle/skip, 1 first byte, 2 second address byte, 3 data
    int m_st = 0;
    logic m_full = 0, m_ovf = 0, m_match = 0, m_ten = 0, m_rw = 0;
    logic [7:0] m_data = 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
        m_st = 1; m_match = 0; m_ten = 0;
        chk("R2 start_seen", start_seen, 1);
        chk("R2 stop_seen", stop_seen, 0);
        chk("R13 addr_match cleared", addr_match, 0);
        chk("R13 ten_bit cleared", ten_bit, 0);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b1; wait_c(Q);
        m_st = 0; m_match = 0; m_ten = 0;
        chk("R2 stop_seen", stop_seen, 1);
        chk("R2 start_seen", start_seen, 0);
        chk("R12 pull after stop", sda_pull, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_c(Q);
            scl_m = 1'b1; wait_c(Q);
            scl_m = 1'b0; wait_c(Q);
        end
        sda_m = 1'b1; wait_c(Q);
        scl_m = 1'b1; wait_c(Q / 2);
        acked = !sda_bus;
        wait_c(Q / 2);
        scl_m = 1'b0; wait_c(Q);
    endtask

    function automatic logic model_byte(input logic [7:0] b);
        logic e = 1'b0;
        case (m_st)
            1: begin
                if (b[7:3] == 5'b11110) begin
                    m_ten = 1'b1;
                    if (b[2:1] == own[9:8] && !b[0]) begin e = 1'b1; m_st = 2; end
                    else m_st = 0;
                end else if (b[7:1] == own[6:0]) begin
                    e = 1'b1; m_match = 1'b1; m_rw = b[0]; m_st = b[0] ? 0 : 3;
                end else m_st = 0;
            end
            2: begin
                if (b == own[7:0]) begin e = 1'b1; m_match = 1'b1; m_rw = 1'b0; m_st = 3; end
                else m_st = 0;
            end
            3: begin
                if (m_full) m_ovf = 1'b1;
                else begin e = 1'b1; m_full = 1'b1; m_data = b; end
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic xfer(input logic [7:0] b, input string tag);
        logic e_ack, a;
        e_ack = model_byte(b);
        send_byte(b, a);
        chk({tag, " ack"}, a, e_ack);
        chk("R3 rx_data", rx_data, m_data);
        chk("R8 rx_full", rx_full, m_full);
        chk("R10 overflow", overflow, m_ovf);
        chk("R4 addr_match", addr_match, m_match);
        chk("R6 ten_bit", ten_bit, m_ten);
        chk("R12 pull released", sda_pull, 0);
        if (m_match) chk("R4 rw_bit", rw_bit, m_rw);
    endtask

    task automatic read_buf();
        rd = 1'b1; wait_c(1);
        rd = 1'b0; wait_c(1);
        m_full = 1'b0; m_ovf = 1'b0;
        chk("R9 rx_full cleared", rx_full, 0);
        chk("R9 overflow cleared", overflow, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = $urandom(32'd7531);
        wait_c(4);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 flags", {overflow, start_seen, stop_seen, ten_bit, addr_match, rw_bit}, 0);
        chk("R1 rx_data", rx_data, 0);
        rst_n = 1'b1;
        wait_c(4);

        // R4/R8/R9: 7-bit write, two bytes with a read in between
        own = 10'h05A;
        do_start();
        xfer({7'h5A, 1'b0}, "R4 addr");
        xfer(8'hC3, "R8 data");
        read_buf();
        xfer(8'h3C, "R9 next data");
        // R10: second byte without read
        xfer(8'hFF, "R10 overflow");
        do_stop();
        read_buf();

        // R5: wrong 7-bit address
        do_start();
        xfer({7'h11, 1'b0}, "R5 addr");
        xfer(8'hA5, "R5 data");
        do_stop();

        // R11: read direction
        do_start();
        xfer({7'h5A, 1'b1}, "R11 addr");
        xfer(8'h77, "R11 data");
        do_stop();

        // R6: 10-bit match
        own = 10'h2B7;
        do_start();
        xfer({5'b11110, 2'b10, 1'b0}, "R6 preamble");
        xfer(8'hB7, "R6 low");
        xfer(8'h81, "R6 data");
        // R13: repeated start with 10-bit low mismatch
        do_start();
        xfer({5'b11110, 2'b10, 1'b0}, "R13 preamble");
        xfer(8'hB6, "R7 low");
        xfer(8'h42, "R7 data");
        do_stop();
        read_buf();

        // Random transfers against the bench model
        for (int it = 0; it < 30; it++) begin
            int kind, n;
            r = $urandom;
            own = r[9:0];
            kind = int'(r[13:12]);
            n = 1 + int'(r[17:16]) % 3;
            do_start();
            r = $urandom;
            case (kind)
                0: xfer({own[6:0], 1'b0}, "R4 rnd addr");
                1: xfer(r[7:0], "R5 rnd addr");
                2: begin
                    xfer({5'b11110, own[9:8], 1'b0}, "R6 rnd preamble");
                    xfer(own[7:0], "R6 rnd low");
                end
                default: begin
                    xfer({5'b11110, own[9:8], 1'b0}, "R6 rnd preamble");
                    xfer(r[15:8], "R7 rnd low");
                end
            endcase
            for (int k = 0; k < n; k++) begin
                r = $urandom;
                xfer(r[7:0], "R8 rnd data");
                if (r[8]) read_buf();
            end
            do_stop();
            read_buf();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule